// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. It has a write side and a read side, and each side runs on its own free-running clock. The two clocks can be one shared clock or two clocks with no phase or frequency relation. A write needs both write qualifiers high on a write-clock rising edge. A read needs both read qualifiers high on a read-clock rising edge. This lets two separate agents each gate the same port.

The block has four flags. Empty and almost-empty live on the read side. Full and almost-full live on the write side. The two threshold flags compare the fill level against offsets that software or a controller loads through a small strobe-and-data interface on the write side. Each offset returns to 7 after reset. The read side has an output enable. When it is low, the data outputs float to high impedance and no FIFO state changes.

The pointers cross between the clock domains as Gray code through two-stage synchronisers. A flag that depends on the other domain can therefore clear a few cycles late, but it never asserts late.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a write-clock rising edge only when wr_en_a and wr_en_b are both 1 and full is 0. With either enable at 0, nothing is stored.
- R2: A word is taken on a read-clock rising edge only when rd_en_a and rd_en_b are both 1 and empty is 0. The word taken appears on rd_data right after that same edge, and rd_data holds its value until the next accepted read.
- R3: Words leave in the order they entered, with their values unchanged. This holds both when the clocks are unrelated and when they are the same clock.
- R4: empty is 1 after reset. It becomes 1 on the edge of the read that takes the last stored word. It returns to 0 within a few read cycles after a write.
- R5: full is 0 after reset. It becomes 1 on the edge of the write that stores the DEPTH-th word.
- R6: A write while full and a read while empty have no effect: the stored words, the pointers and rd_data stay unchanged.
- R7: After reset, with no offset loaded, almost_empty is 1 exactly when the FIFO holds 7 or fewer words (checked once the flags have settled).
- R8: After reset, with no offset loaded, almost_full is 1 exactly when the FIFO holds DEPTH-7 or more words (checked once the flags have settled).
- R9: A write-clock edge with ofs_load=1 loads ofs_data as the offset that ofs_sel selects: ofs_sel=0 selects the almost-empty offset and ofs_sel=1 selects the almost-full offset. almost_empty is then 1 when the level is at most that offset. almost_full is then 1 when the level is at least DEPTH minus that offset. Reset restores 7 for both offsets.
- R10: While out_en is 0, rd_data does not present the stored word (it is high impedance). Reads still proceed normally. When out_en returns to 1, the last word read is driven.
- R11: full implies almost_full, and empty implies almost_empty, at every edge of the clock that owns each flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous reset for the write side, active high |
| wr_en_a | input | 1 | First write qualifier |
| wr_en_b | input | 1 | Second write qualifier |
| wr_data | input | 9 | Word to store |
| full | output | 1 | No free space (write side) |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| ofs_load | input | 1 | Strobe that loads an offset (write side) |
| ofs_sel | input | 1 | 0 selects the almost-empty offset, 1 selects the almost-full offset |
| ofs_data | input | log2(DEPTH) | Offset value to load |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous reset for the read side, active high |
| rd_en_a | input | 1 | First read qualifier |
| rd_en_b | input | 1 | Second read qualifier |
| out_en | input | 1 | Output enable; 0 floats rd_data |
| rd_data | output | 9 | Registered read word |
| empty | output | 1 | No stored words (read side) |
| almost_empty | output | 1 | Level at or below the almost-empty offset |

## Verification
The hardest situation to reach is a change of the almost-empty offset, because that value is loaded on the write side but used on the read side. It only takes effect after a toggle crosses the synchroniser. The bench loads both offsets, waits for the crossing to complete, and then steps the fill level one word at a time across both new thresholds. It then resets the block and steps across the default thresholds again to show that the loaded offsets were discarded. The ordering checks with unrelated clocks use a free-running writer and reader at different rates, each obeying only its own flag, so full and empty are both reached while the Gray pointers move in both directions.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
    localparam int unsigned WORD_W  = 9;
    localparam int unsigned DEF_OFS = 7;

    typedef enum logic {
        SEL_AEMPTY = 1'b0,
        SEL_AFULL  = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
    parameter int W     = 9,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] ram [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            ram[waddr] <= wdata;
        end
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/xfifo_wr.sv
module xfifo_wr #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [PW-1:0] rgray_s,
    input  logic          ofs_load,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_data,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          afull,
    output logic [AW-1:0] ae_ofs,
    output logic          ae_tog
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
        logic [AW-1:0] ae_ofs;
        logic [AW-1:0] af_ofs;
        logic          tog;
    } wstate_t;

    wstate_t s_d, s_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] nxt;
    logic [PW-1:0] lvl;
    logic          push;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin[i] = ^(rgray_s >> i);
        end
        s_d    = s_q;
        push   = en_a & en_b & ~s_q.full;
        nxt    = s_q.bin + PW'(push);
        s_d.bin  = nxt;
        s_d.gray = nxt ^ (nxt >> 1);
        s_d.full = (s_d.gray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
        lvl      = nxt - rbin;
        s_d.afull = (lvl >= (PW'(DEPTH) - {1'b0, s_q.af_ofs}));
        if (ofs_load) begin
            if (ofs_sel == xfifo_pkg::SEL_AFULL) begin
                s_d.af_ofs = ofs_data;
            end else begin
                s_d.ae_ofs = ofs_data;
                s_d.tog    = ~s_q.tog;
            end
        end
        if (rst) begin
            s_d.bin    = '0;
            s_d.gray   = '0;
            s_d.full   = 1'b0;
            s_d.afull  = 1'b0;
            s_d.ae_ofs = AW'(xfifo_pkg::DEF_OFS);
            s_d.af_ofs = AW'(xfifo_pkg::DEF_OFS);
            s_d.tog    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign we     = push & ~rst;
    assign waddr  = s_q.bin[AW-1:0];
    assign wgray  = s_q.gray;
    assign full   = s_q.full;
    assign afull  = s_q.afull;
    assign ae_ofs = s_q.ae_ofs;
    assign ae_tog = s_q.tog;
endmodule

// File: rtl/xfifo_rd.sv
module xfifo_rd #(
    parameter int W  = 9,
    parameter int AW = 8,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [PW-1:0] wgray_s,
    input  logic          tog_s,
    input  logic [AW-1:0] ae_ofs_w,
    input  logic [W-1:0]  mem_data,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          aempty,
    output logic [W-1:0]  dout
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
        logic [AW-1:0] ae_ofs;
        logic          tog_seen;
        logic [W-1:0]  dout;
    } rstate_t;

    rstate_t s_d, s_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] nxt;
    logic [PW-1:0] lvl;
    logic          pop;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin[i] = ^(wgray_s >> i);
        end
        s_d      = s_q;
        pop      = en_a & en_b & ~s_q.empty;
        nxt      = s_q.bin + PW'(pop);
        s_d.bin  = nxt;
        s_d.gray = nxt ^ (nxt >> 1);
        s_d.empty  = (s_d.gray == wgray_s);
        lvl        = wbin - nxt;
        s_d.aempty = (lvl <= {1'b0, s_q.ae_ofs});
        if (pop) begin
            s_d.dout = mem_data;
        end
        if (tog_s != s_q.tog_seen) begin
            s_d.ae_ofs   = ae_ofs_w;
            s_d.tog_seen = tog_s;
        end
        if (rst) begin
            s_d.bin      = '0;
            s_d.gray     = '0;
            s_d.empty    = 1'b1;
            s_d.aempty   = 1'b1;
            s_d.ae_ofs   = AW'(xfifo_pkg::DEF_OFS);
            s_d.tog_seen = tog_s;
            s_d.dout     = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign raddr  = s_q.bin[AW-1:0];
    assign rgray  = s_q.gray;
    assign empty  = s_q.empty;
    assign aempty = s_q.aempty;
    assign dout   = s_q.dout;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = xfifo_pkg::WORD_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    input  logic              ofs_load,
    input  logic              ofs_sel,
    input  logic [AW-1:0]     ofs_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty
);
    logic              we;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [PW-1:0]     wgray_q;
    logic [PW-1:0]     rgray_q;
    logic [PW-1:0]     wgray_rs;
    logic [PW-1:0]     rgray_ws;
    logic [AW-1:0]     ae_ofs_w;
    logic              ae_tog_w;
    logic              ae_tog_rs;
    logic [DATA_W-1:0] mem_data;
    logic [DATA_W-1:0] dout_q;

    xfifo_wr #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .en_a     (wr_en_a),
        .en_b     (wr_en_b),
        .rgray_s  (rgray_ws),
        .ofs_load (ofs_load),
        .ofs_sel  (ofs_sel),
        .ofs_data (ofs_data),
        .we       (we),
        .waddr    (waddr),
        .wgray    (wgray_q),
        .full     (full),
        .afull    (almost_full),
        .ae_ofs   (ae_ofs_w),
        .ae_tog   (ae_tog_w)
    );

    xfifo_mem #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_data)
    );

    xfifo_sync #(.W(PW)) u_sync_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray_q),
        .q   (rgray_ws)
    );

    xfifo_sync #(.W(PW)) u_sync_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray_q),
        .q   (wgray_rs)
    );

    xfifo_sync #(.W(1)) u_sync_tog (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (ae_tog_w),
        .q   (ae_tog_rs)
    );

    xfifo_rd #(.W(DATA_W), .AW(AW), .PW(PW)) u_rd (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .en_a     (rd_en_a),
        .en_b     (rd_en_b),
        .wgray_s  (wgray_rs),
        .tog_s    (ae_tog_rs),
        .ae_ofs_w (ae_ofs_w),
        .mem_data (mem_data),
        .raddr    (raddr),
        .rgray    (rgray_q),
        .empty    (empty),
        .aempty   (almost_empty),
        .dout     (dout_q)
    );

    assign rd_data = out_en ? dout_q : {DATA_W{1'bz}};
endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_en_a,
    input logic          wr_en_b,
    input logic          rd_en_a,
    input logic          rd_en_b,
    input logic          full,
    input logic          almost_full,
    input logic          empty,
    input logic          almost_empty,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);
    a_r1_no_write_without_both: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!wr_en_a || !wr_en_b) |=> $stable(wgray));

    a_r2_no_read_without_both: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!rd_en_a || !rd_en_b) |=> $stable(rgray));

    a_r6_full_blocks_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (full && wr_en_a && wr_en_b) |=> $stable(wgray));

    a_r6_empty_blocks_read: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (empty && rd_en_a && rd_en_b) |=> $stable(rgray));

    a_r3_wgray_one_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $onehot0(wgray ^ $past(wgray)));

    a_r3_rgray_one_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $onehot0(rgray ^ $past(rgray)));

    a_r11_full_has_afull: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |-> almost_full);

    a_r11_empty_has_aempty: assert property (@(posedge rd_clk) disable iff (rd_rst)
        empty |-> almost_empty);
endmodule

bind xclk_fifo xfifo_chk #(.PW(PW)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst       (wr_rst),
    .rd_clk       (rd_clk),
    .rd_rst       (rd_rst),
    .wr_en_a      (wr_en_a),
    .wr_en_b      (wr_en_b),
    .rd_en_a      (rd_en_a),
    .rd_en_b      (rd_en_b),
    .full         (full),
    .almost_full  (almost_full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .wgray        (wgray_q),
    .rgray        (rgray_q)
);

// File: tb/sim_xclk_fifo.sv
module sim_xclk_fifo;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic wclk = 1'b0;
    logic rclk_free = 1'b0;
    logic same_clk = 1'b1;
    wire  rclk = same_clk ? wclk : rclk_free;

    always #4 wclk = ~wclk;
    always #7 rclk_free = ~rclk_free;

    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic          wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0;
    logic [8:0]    wr_data = '0;
    logic          ofs_load = 0, ofs_sel = 0, out_en = 1;
    logic [AW-1:0] ofs_data = '0;
    wire  [8:0]    rd_data;
    wire           full, almost_full, empty, almost_empty;

    int total = 0;
    int bad = 0;
    logic [8:0] model[$];

    xclk_fifo #(.DEPTH(DEPTH)) u0 (
        .wr_clk(wclk), .wr_rst(wr_rst), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
        .wr_data(wr_data), .full(full), .almost_full(almost_full),
        .ofs_load(ofs_load), .ofs_sel(ofs_sel), .ofs_data(ofs_data),
        .rd_clk(rclk), .rd_rst(rd_rst), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
        .out_en(out_en), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_reset();
        @(negedge wclk);
        wr_rst = 1; rd_rst = 1;
        wr_en_a = 0; wr_en_b = 0; rd_en_a = 0; rd_en_b = 0;
        ofs_load = 0; out_en = 1;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        wr_rst = 0; rd_rst = 0;
        model.delete();
        settle();
    endtask

    task automatic push(input logic [8:0] v, output bit acc);
        @(negedge wclk);
        acc = !full;
        wr_en_a = 1; wr_en_b = 1; wr_data = v;
        @(negedge wclk);
        wr_en_a = 0; wr_en_b = 0;
        if (acc) model.push_back(v);
    endtask

    task automatic pop(output logic [8:0] v, output bit took);
        @(negedge rclk);
        took = !empty;
        rd_en_a = 1; rd_en_b = 1;
        @(negedge rclk);
        rd_en_a = 0; rd_en_b = 0;
        v = rd_data;
    endtask

    task automatic load_ofs(input logic sel, input logic [AW-1:0] val);
        @(negedge wclk);
        ofs_load = 1; ofs_sel = sel; ofs_data = val;
        @(negedge wclk);
        ofs_load = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(empty == 1'b1, "R4 empty after reset", empty, 1);
        check(almost_empty == 1'b1, "R7 almost_empty after reset", almost_empty, 1);
        check(full == 1'b0, "R5 full after reset", full, 0);
        check(almost_full == 1'b0, "R8 almost_full after reset", almost_full, 0);
        check(rd_data == 9'd0, "R2 rd_data after reset", rd_data, 0);
    endtask

    task automatic t_enables();
        logic [8:0] v;
        bit took, acc;
        do_reset();
        @(negedge wclk); wr_data = 9'h1AA; wr_en_a = 1; wr_en_b = 0;
        @(negedge wclk); wr_en_a = 0; wr_en_b = 1;
        @(negedge wclk); wr_en_b = 0;
        settle();
        check(empty == 1'b1, "R1 single write enable stores nothing", empty, 1);
        push(9'h055, acc);
        settle();
        check(empty == 1'b0, "R4 empty clears after write", empty, 0);
        @(negedge rclk); rd_en_a = 1;
        @(negedge rclk); rd_en_a = 0; rd_en_b = 1;
        @(negedge rclk); rd_en_b = 0;
        settle();
        check(empty == 1'b0, "R2 single read enable takes nothing", empty, 0);
        check(rd_data == 9'd0, "R2 rd_data unchanged without read", rd_data, 0);
        pop(v, took);
        check(took && v == 9'h055, "R2 read data next edge", v, 9'h055);
        check(empty == 1'b1, "R4 empty on last read edge", empty, 1);
    endtask

    task automatic t_fill_drain();
        logic [8:0] v;
        logic [8:0] exp;
        bit took, acc;
        do_reset();
        for (int k = 1; k <= DEPTH; k++) begin
            push(9'(k * 29 + 5), acc);
            if (k == DEPTH) check(full == 1'b1, "R5 full on filling write edge", full, 1);
            settle();
            check(empty == (k == 0), "R4 empty vs level", empty, 0);
            check(almost_empty == (k <= 7), "R7 almost_empty default", almost_empty, k <= 7);
            check(almost_full == (k >= DEPTH - 7), "R8 almost_full default", almost_full, k >= DEPTH - 7);
            check(full == (k == DEPTH), "R5 full vs level", full, k == DEPTH);
        end
        push(9'h1FF, acc);
        check(!acc && full == 1'b1, "R6 write while full refused", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            exp = model.pop_front();
            pop(v, took);
            check(took && v == exp, "R3 order and value", v, exp);
        end
        check(empty == 1'b1, "R4 empty on last read edge", empty, 1);
        exp = v;
        pop(v, took);
        check(!took && rd_data == exp, "R6 read while empty keeps rd_data", rd_data, exp);
        push(9'h0A5, acc);
        settle();
        pop(v, took);
        check(took && v == 9'h0A5, "R6 pointers unchanged by ignored read", v, 9'h0A5);
    endtask

    task automatic t_offsets();
        bit acc;
        do_reset();
        load_ofs(1'b0, 4'd3);
        load_ofs(1'b1, 4'd2);
        settle();
        for (int k = 1; k <= DEPTH; k++) begin
            push(9'(k), acc);
            settle();
            if (k == 3) check(almost_empty == 1'b1, "R9 ae at loaded offset", almost_empty, 1);
            if (k == 4) check(almost_empty == 1'b0, "R9 ae above loaded offset", almost_empty, 0);
            if (k == 13) check(almost_full == 1'b0, "R9 af below loaded threshold", almost_full, 0);
            if (k == 14) check(almost_full == 1'b1, "R9 af at loaded threshold", almost_full, 1);
        end
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            push(9'(k), acc);
            settle();
            if (k == 5) check(almost_empty == 1'b1, "R9 ae default restored", almost_empty, 1);
            if (k == 8) check(almost_full == 1'b0, "R9 af default restored below", almost_full, 0);
            if (k == 9) check(almost_full == 1'b1, "R9 af default restored at", almost_full, 1);
        end
    endtask

    task automatic t_out_enable();
        logic [8:0] v;
        bit took, acc;
        do_reset();
        push(9'h13C, acc);
        settle();
        out_en = 0;
        pop(v, took);
        check(!(v === 9'h13C), "R10 disabled output hides word", v, 0);
        check(empty == 1'b1, "R10 read proceeds while disabled", empty, 1);
        out_en = 1;
        #1;
        check(rd_data == 9'h13C, "R10 word driven after enable", rd_data, 9'h13C);
    endtask

    task automatic t_async();
        same_clk = 0;
        do_reset();
        fork
            begin
                bit acc;
                for (int n = 0; n < 40; ) begin
                    push(9'((n * 7 + 3) & 9'h1FF), acc);
                    if (acc) n++;
                end
            end
            begin
                logic [8:0] v;
                bit took;
                for (int n = 0; n < 40; ) begin
                    if (n < 12) repeat (3) @(negedge rclk);
                    pop(v, took);
                    if (took) begin
                        check(v == 9'((n * 7 + 3) & 9'h1FF), "R3 async order", v, (n * 7 + 3) & 9'h1FF);
                        n++;
                    end
                end
            end
        join
        settle();
        check(empty == 1'b1, "R4 empty after async drain", empty, 1);
        same_clk = 1;
        do_reset();
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_enables();
                t_fill_drain();
                t_offsets();
                t_out_enable();
                t_async();
            end
            begin
                #1000000;
                bad++;
                total++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule